// File: doc/BRIEF.md
# Sequential Restoring Unsigned Divider

This block divides one WIDTH-bit unsigned number by another over several clock cycles, producing a quotient and a remainder. It holds a single 2·WIDTH-bit working register whose upper half carries the partial remainder and whose lower half collects quotient bits as the whole register moves left, one bit per cycle. A single subtractor runs beside it. A trial subtraction that comes out negative leaves the partial remainder as it was, which restores it. After the last step the upper half has moved one place too far, so one extra cycle moves it right by one bit.

A caller pulses `start` with both operands while the block is idle. The block is then `busy` for WIDTH+1 cycles. It raises `done` for one cycle, and the results stay on the outputs until the next accepted start. A zero divisor skips the loop. The result is returned on the next cycle with `divZero` set.

Top module: `seqDivider`

## Requirements
- R1: While reset is held and right after it, `busy`, `done` and `divZero` are 0, and `quotient` and `remainder` are all zeros.
- R2: When `start` is sampled high at clock edge k while `busy` is low and `divisor` is nonzero, `busy` is high from edge k to edge k+WIDTH+1, and `done` is high only in the cycle after edge k+WIDTH+1.
- R3: For a nonzero divisor, at `done` the `quotient` equals the dividend divided by the divisor rounded down, and the `remainder` equals the dividend minus quotient times divisor, which is always less than the divisor.
- R4: Dividing 7 by 2 gives a quotient of 3 and a remainder of 1.
- R5: When `start` is accepted with `divisor` equal to 0, in the next cycle `done` and `divZero` are 1, `quotient` is all ones, `remainder` equals the dividend, and `busy` stays 0.
- R6: An accepted start with a nonzero divisor clears `divZero`, which then stays 0 through to that operation's `done`.
- R7: `start` pulses while `busy` is high are ignored: the running operation's operands and result are unchanged.
- R8: A `start` in the same cycle as `done` is accepted and begins a new operation at once.
- R9: While idle and `start` is low, `quotient`, `remainder` and `divZero` keep their values.
- R10: `done` is a single-cycle pulse during which `busy` is low, and every fall of `busy` comes with `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division; sampled only while idle |
| dividend | input | WIDTH | Unsigned dividend, sampled with start |
| divisor | input | WIDTH | Unsigned divisor, sampled with start |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse when results are valid |
| divZero | output | 1 | Last accepted divisor was zero |
| quotient | output | WIDTH | Quotient, valid from done until next accepted start |
| remainder | output | WIDTH | Remainder, valid from done until next accepted start |

## Verification
The result pulse and the acceptance of a new operation can fall in the same cycle, because the block is idle again during its `done` cycle. The bench raises `start` with fresh operands exactly when it sees `done`. It then checks that `busy` rises on the next edge and that the second result matches the new operands, while the first result was still correct during the pulse. The same overlap is also driven with a zero divisor right after a normal result. A per-cycle behavioural model judges `busy`, `done` and `divZero` in every cycle.

// File: rtl/divPkg.sv
package divPkg;

  // strobes from the sequencer to the datapath, at most one high per cycle
  typedef struct packed {
    logic load;      // capture operands, pre-shifted by one bit
    logic loadZero;  // zero-divisor shortcut result
    logic iterate;   // one trial subtract and shift
    logic fix;       // pull the over-shifted remainder back by one bit
  } divCtrlT;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } divStateT;

endpackage

// File: rtl/divDatapath.sv
module divDatapath
  import divPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  divCtrlT          ctrl,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);

  localparam int W = WIDTH;

  logic [W-1:0] hiQ;       // partial remainder
  logic [W-1:0] loQ;       // dividend bits leaving, quotient bits entering
  logic         spillQ;    // bit shifted out of hiQ, extends it to W+1 bits
  logic [W-1:0] divReg;

  logic [W:0]   trial;
  logic         trialNeg;
  logic [W-1:0] keep;

  // {spill,hi} < 2*divisor, so an (W+1)-bit difference has an exact sign bit
  assign trial    = {spillQ, hiQ} - {1'b0, divReg};
  assign trialNeg = trial[W];
  assign keep     = trialNeg ? hiQ : trial[W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiQ    <= '0;
      loQ    <= '0;
      spillQ <= 1'b0;
      divReg <= '0;
    end else if (ctrl.load) begin
      hiQ    <= {{(W-1){1'b0}}, dividend[W-1]};
      loQ    <= {dividend[W-2:0], 1'b0};
      spillQ <= 1'b0;
      divReg <= divisor;
    end else if (ctrl.loadZero) begin
      hiQ    <= dividend;
      loQ    <= '1;
      spillQ <= 1'b0;
      divReg <= divisor;
    end else if (ctrl.iterate) begin
      spillQ <= keep[W-1];
      hiQ    <= {keep[W-2:0], loQ[W-1]};
      loQ    <= {loQ[W-2:0], ~trialNeg};
    end else if (ctrl.fix) begin
      hiQ    <= {spillQ, hiQ[W-1:1]};
      spillQ <= 1'b0;
    end
  end

  assign quotient  = loQ;
  assign remainder = hiQ;

endmodule

// File: rtl/divControl.sv
module divControl
  import divPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    divisorIsZero,
  output divCtrlT ctrl,
  output logic    busy,
  output logic    done,
  output logic    divZero
);

  localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH - 1);

  divStateT      stateQ, stateD;
  logic [CW-1:0] stepQ;
  logic          accept;

  assign accept = (stateQ == ST_IDLE) && start;
  assign busy   = (stateQ != ST_IDLE);

  always_comb begin
    ctrl   = '0;
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: begin
        if (accept) begin
          if (divisorIsZero) begin
            ctrl.loadZero = 1'b1;
          end else begin
            ctrl.load = 1'b1;
            stateD    = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        ctrl.iterate = 1'b1;
        if (stepQ == LAST_STEP) stateD = ST_FIX;
      end
      ST_FIX: begin
        ctrl.fix = 1'b1;
        stateD   = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      stepQ   <= '0;
      done    <= 1'b0;
      divZero <= 1'b0;
    end else begin
      stateQ <= stateD;
      done   <= ctrl.fix | ctrl.loadZero;
      if (accept) divZero <= divisorIsZero;
      if (ctrl.load)         stepQ <= '0;
      else if (ctrl.iterate) stepQ <= stepQ + 1'b1;
    end
  end

endmodule

// File: rtl/seqDivider.sv
module seqDivider
  import divPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic             divZero,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);

  divCtrlT ctrl;
  logic    divisorIsZero;

  assign divisorIsZero = (divisor == '0);

  divControl #(.WIDTH(WIDTH)) u_control (
    .clk           (clk),
    .rstN          (rstN),
    .start         (start),
    .divisorIsZero (divisorIsZero),
    .ctrl          (ctrl),
    .busy          (busy),
    .done          (done),
    .divZero       (divZero)
  );

  divDatapath #(.WIDTH(WIDTH)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .dividend  (dividend),
    .divisor   (divisor),
    .quotient  (quotient),
    .remainder (remainder)
  );

endmodule

// File: rtl/seqDividerChecker.sv
module seqDividerChecker #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [WIDTH-1:0] dividend,
  input logic [WIDTH-1:0] divisor,
  input logic             busy,
  input logic             done,
  input logic             divZero,
  input logic [WIDTH-1:0] quotient,
  input logic [WIDTH-1:0] remainder
);

  logic [WIDTH-1:0]   capA, capB;
  int unsigned        sinceStart;
  logic [2*WIDTH-1:0] rebuilt;
  logic               takeNew;

  assign takeNew = start && !busy;
  assign rebuilt = {{WIDTH{1'b0}}, quotient} * {{WIDTH{1'b0}}, capB}
                 + {{WIDTH{1'b0}}, remainder};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capA       <= '0;
      capB       <= '0;
      sinceStart <= 0;
    end else if (takeNew) begin
      capA       <= dividend;
      capB       <= divisor;
      sinceStart <= 0;
    end else if (busy) begin
      sinceStart <= sinceStart + 1;
    end
  end

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (takeNew && divisor != '0) |=> (busy && !done));

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    (done && !divZero) |-> (sinceStart == WIDTH + 1));

  assert_result_R3: assert property (@(posedge clk) disable iff (!rstN)
    (done && !divZero) |-> (rebuilt == {{WIDTH{1'b0}}, capA} && remainder < capB));

  assert_zero_shortcut_R5: assert property (@(posedge clk) disable iff (!rstN)
    (takeNew && divisor == '0) |=>
      (done && divZero && !busy && quotient == '1 && remainder == $past(dividend)));

  assert_zero_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (takeNew && divisor != '0) |=> !divZero);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(quotient) && $stable(remainder) && $stable(divZero)));

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_busy_end_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

endmodule

bind seqDivider seqDividerChecker #(.WIDTH(WIDTH)) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .dividend  (dividend),
  .divisor   (divisor),
  .busy      (busy),
  .done      (done),
  .divZero   (divZero),
  .quotient  (quotient),
  .remainder (remainder)
);

// File: tb/test_seqDivider.sv
module test_seqDivider;

  localparam int N = 32;
  localparam int LIMIT = 150000;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [N-1:0] dividend = '0;
  logic [N-1:0] divisor = '0;
  logic         busy, done, divZero;
  logic [N-1:0] quotient, remainder;

  always #10 clk = ~clk;  // 50 MHz

  seqDivider #(.WIDTH(N)) i_seqDivider (
    .clk(clk), .rstN(rstN), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .divZero(divZero), .quotient(quotient), .remainder(remainder)
  );

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 0;

  // behavioural reference, advanced at each rising edge
  logic         mBusy = 0, mDone = 0, mZero = 0;
  logic [N-1:0] mQ = '0, mR = '0, mA = '0, mB = '0;
  int           mCnt = 0;

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mBusy = 0; mDone = 0; mZero = 0; mQ = '0; mR = '0; mCnt = 0;
    end else if (!mBusy) begin
      mDone = 0;
      if (start) begin
        if (divisor == '0) begin
          mDone = 1; mZero = 1; mQ = '1; mR = dividend;
        end else begin
          mBusy = 1; mCnt = 0; mZero = 0; mA = dividend; mB = divisor;
        end
      end
    end else begin
      mDone = 0;
      mCnt++;
      if (mCnt == N + 1) begin
        mBusy = 0; mDone = 1; mQ = mA / mB; mR = mA % mB;
      end
    end
    if (cycles >= LIMIT && !finished) begin
      fails++;
      checks++;
      $display("FAIL R2 watchdog: actual no completion, expected completion within %0d cycles", LIMIT);
      summary();
    end
  end

  task automatic summary();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R2 busy", N'(busy), N'(mBusy));
      check("R10 done", N'(done), N'(mDone));
      check("R5 divZero", N'(divZero), N'(mZero));
      if (!mBusy) begin
        check("R3 quotient", quotient, mQ);
        check("R3 remainder", remainder, mR);
      end
    end
  end

  task automatic launch(logic [N-1:0] a, logic [N-1:0] b);
    start = 1; dividend = a; divisor = b;
    @(negedge clk);
    start = 0;
  endtask

  task automatic waitDone();
    while (!done) @(negedge clk);
  endtask

  task automatic runOp(string tag, logic [N-1:0] a, logic [N-1:0] b);
    launch(a, b);
    waitDone();
    if (b == '0) begin
      check({tag, " zero quotient"}, quotient, '1);
      check({tag, " zero remainder"}, remainder, a);
    end else begin
      check({tag, " quotient"}, quotient, a / b);
      check({tag, " remainder"}, remainder, a % b);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy in reset", N'(busy), '0);
    check("R1 quotient in reset", quotient, '0);
    rstN = 1;
    @(negedge clk);
    check("R1 done after reset", N'(done), '0);
    check("R1 divZero after reset", N'(divZero), '0);
    check("R1 remainder after reset", remainder, '0);

    runOp("R4", 7, 2);
    check("R4 quotient 3", quotient, 3);
    check("R4 remainder 1", remainder, 1);
    check("R10 busy low at done", N'(busy), '0);
    @(negedge clk);
    check("R10 done single pulse", N'(done), '0);

    runOp("R3 max/1", '1, 1);
    runOp("R3 max/max", '1, '1);
    runOp("R3 small/large", 5, '1);
    runOp("R3 zero dividend", 0, 7);
    runOp("R3 msb/3", {1'b1, {(N-1){1'b0}}}, 3);
    runOp("R3 max/msb", '1, {1'b1, {(N-1){1'b0}}});

    // R8: start in the done cycle, twice in a row
    launch(100, 7);
    waitDone();
    check("R8 first quotient", quotient, 14);
    launch(1000, 33);
    check("R8 busy after back-to-back start", N'(busy), 1);
    waitDone();
    check("R8 second quotient", quotient, 1000 / 33);
    check("R8 second remainder", remainder, 1000 % 33);
    launch(55, 0);
    check("R8 zero start in done cycle", N'(done), 1);
    check("R8 zero result remainder", remainder, 55);

    // R9: outputs hold while idle
    runOp("R9 setup", 123456, 789);
    repeat (10) @(negedge clk);
    check("R9 quotient held", quotient, 123456 / 789);
    check("R9 remainder held", remainder, 123456 % 789);

    // R7: start while busy ignored
    launch(9999, 10);
    repeat (5) @(negedge clk);
    launch(77, 5);
    waitDone();
    check("R7 quotient from first operands", quotient, 999);
    check("R7 remainder from first operands", remainder, 9);

    // R5 and R6
    launch(32'h1234, 0);
    check("R5 done next cycle", N'(done), 1);
    check("R5 busy stays low", N'(busy), 0);
    check("R5 flag", N'(divZero), 1);
    check("R5 quotient all ones", quotient, '1);
    check("R5 remainder is dividend", remainder, 32'h1234);
    launch(9, 4);
    check("R6 flag cleared on start", N'(divZero), 0);
    waitDone();
    check("R6 flag low at done", N'(divZero), 0);
    check("R6 quotient", quotient, 2);

    for (int i = 0; i < 30; i++) begin
      logic [N-1:0] a, b;
      a = $urandom;
      b = $urandom >> (i % N);
      runOp("R3 random", a, b);
    end

    repeat (3) @(negedge clk);
    summary();
  end

endmodule